// File: doc/BRIEF.md
# Control Store Loader Port

This block lets a host fill an engine's instruction store through three write-only host registers that share one small offset space. The host first writes the index register with the programming-enable bit set and a start index. It then pushes each instruction word as two writes: a lower data write that is only staged, and an upper data write that commits the whole word to the store and moves the index on by one. When the index passes the last store location it returns to zero.

Each stored word holds a 40-bit instruction and two even-parity bits, one for each 20-bit half. The host computes these bits. The block checks them at commit time when the parity-check input is high. A failed check raises a sticky error flag that only reset clears. Writing zero to the index register ends programming. While programming is off, data writes are dropped.

The store itself sits outside the block. The block drives a one-cycle write strobe, an address and a 42-bit word, and it presents the index register's current value for readback.

Top module: `cs_prog_port`

## Requirements
- R1: After reset the index readback `idx_rd` is 0x00000000, `store_we` is low and `parity_err` is low.
- R2: A host write at offset 0x000 loads bit 31 as the programming-enable bit and the low index bits as the index. `idx_rd` then reads {enable, zeros, index} in the next cycle. Writing 0x00000000 turns programming off.
- R3: While programming is enabled, a write at offset 0x004 only stages 32 bits as word bits 31:0, and `store_we` stays low.
- R4: While programming is enabled, a write at offset 0x008 commits a word to the store. The word is {wdata[9:0], staged lower bits}. In the cycle after the write, `store_we` is high for exactly one cycle, `store_addr` equals the index the write found, and `store_wdata` equals the word.
- R5: Each commit increments the index by one, and the new index is visible on `idx_rd` in the same cycle as the strobe.
- R6: A commit at index DEPTH-1 sets the index to 0, so `idx_rd` then reads 0x80000000.
- R7: While programming is off, writes at offsets 0x004 and 0x008 are ignored. They produce no strobe and leave the staged lower bits and the index unchanged.
- R8: When `par_chk_en` is high at a commit, the word is checked. If bit 40 differs from the XOR of bits 19:0, or bit 41 differs from the XOR of bits 39:20, `parity_err` goes high in the cycle after the write and stays high until reset.
- R9: When `par_chk_en` is low at a commit, no parity mismatch sets `parity_err`.
- R10: Host writes at any offset other than 0x000, 0x004 and 0x008 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_offs | input | 12 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| par_chk_en | input | 1 | Enables the parity check at commit |
| idx_rd | output | 32 | Index register readback {enable, zeros, index} |
| store_we | output | 1 | Store write strobe |
| store_addr | output | $clog2(DEPTH) | Store write address |
| store_wdata | output | 42 | Store write word: parity bits 41:40, instruction bits 39:0 |
| parity_err | output | 1 | Sticky parity error flag |

## Verification
The assertions check, on every cycle, the following properties:
- every strobe traces back to an enabled upper-data write;
- the strobe address is the index that write found;
- the index has moved on, wrapping at the last location, when the strobe appears;
- the index register holds still while programming is off and no index write arrives;
- the error flag stays set once raised, and it only rises on a checked commit whose word fails a half-parity test.

Only the bench scenarios can show the following:
- the committed word pairs the right staged lower bits with the right upper bits;
- a full pass through the store wraps the index readback to 0x80000000;
- dropped writes while programming is off leave the staged bits untouched;
- each parity half is tested on its own.

// File: rtl/cs_prog_pkg.sv
package cs_prog_pkg;

   // host register offsets (fixed: the host software decodes them)
   localparam logic [11:0] OFF_INDEX = 12'h000;
   localparam logic [11:0] OFF_LOW   = 12'h004;
   localparam logic [11:0] OFF_HIGH  = 12'h008;

   // programming enable position inside the index register
   localparam int PROG_EN_BIT = 31;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_INDEX = 2'd1,
      SEL_LOW   = 2'd2,
      SEL_HIGH  = 2'd3
   } cs_sel_e;

   function automatic cs_sel_e cs_decode(input logic [11:0] offs);
      cs_sel_e s;
      unique case (offs)
         OFF_INDEX: s = SEL_INDEX;
         OFF_LOW:   s = SEL_LOW;
         OFF_HIGH:  s = SEL_HIGH;
         default:   s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/cs_index_reg.sv
module cs_index_reg #(
   parameter int DEPTH = 4096,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic             adv,
   output logic             prog_en,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   logic [IDX_W-1:0] idx_nxt;

   always_comb begin
      if (idx == LAST_IDX) idx_nxt = '0;
      else                 idx_nxt = idx + IDX_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_en <= 1'b0;
         idx     <= '0;
      end else if (ld) begin
         prog_en <= ld_en;
         idx     <= ld_idx;
      end else if (adv) begin
         idx     <= idx_nxt;
      end
   end

endmodule

// File: rtl/cs_data_stage.sv
module cs_data_stage #(
   parameter int LOW_W = 32,
   parameter int UPPER_W = 10,
   localparam int WORD_W = LOW_W + UPPER_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_low,
   input  logic [LOW_W-1:0]   low_in,
   input  logic [UPPER_W-1:0] upper_in,
   output logic [WORD_W-1:0]  word
);

   logic [LOW_W-1:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_q <= '0;
      else if (ld_low) low_q <= low_in;
   end

   // incoming upper bits joined with the staged lower bits
   assign word = {upper_in, low_q};

endmodule

// File: rtl/cs_parity_chk.sv
module cs_parity_chk #(
   parameter int HALF_W = 20,
   localparam int INSN_W = 2 * HALF_W,
   localparam int STORE_W = INSN_W + 2
) (
   input  logic [STORE_W-1:0] word,
   output logic               bad
);

   logic [1:0] half_ok;

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         // even parity: the stored bit equals the XOR of its half
         assign half_ok[h] = ((^word[h*HALF_W +: HALF_W]) == word[INSN_W + h]);
      end
   endgenerate

   assign bad = ~&half_ok;

endmodule

// File: rtl/cs_prog_port.sv
module cs_prog_port #(
   parameter int DEPTH   = 4096,
   parameter int HALF_W  = 20,
   parameter bit OUT_REG = 1'b1,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int STORE_W = 2 * HALF_W + 2,
   localparam int UPPER_W = STORE_W - 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [11:0]        host_offs,
   input  logic [31:0]        host_wdata,
   input  logic               par_chk_en,
   output logic [31:0]        idx_rd,
   output logic               store_we,
   output logic [IDX_W-1:0]   store_addr,
   output logic [STORE_W-1:0] store_wdata,
   output logic               parity_err
);
   import cs_prog_pkg::*;

   // elaboration checks
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         begin : g_bad_depth
            $error("DEPTH must be a power of two of at least 2");
         end
      if (IDX_W > 31) begin : g_bad_idx
         $error("index must fit below the enable bit");
      end
      if (UPPER_W < 1 || STORE_W > 64) begin : g_bad_word
         $error("word width out of range");
      end
   endgenerate

   cs_sel_e          sel;
   logic             prog_en;
   logic [IDX_W-1:0] idx;
   logic             wr_index, ld_low, commit;
   logic [STORE_W-1:0] word;
   logic             word_bad;

   assign sel      = cs_decode(host_offs);
   assign wr_index = host_wr && (sel == SEL_INDEX);
   assign ld_low   = host_wr && prog_en && (sel == SEL_LOW);
   assign commit   = host_wr && prog_en && (sel == SEL_HIGH);

   cs_index_reg #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (wr_index),
      .ld_en   (host_wdata[PROG_EN_BIT]),
      .ld_idx  (host_wdata[IDX_W-1:0]),
      .adv     (commit),
      .prog_en (prog_en),
      .idx     (idx)
   );

   cs_data_stage #(.LOW_W(32), .UPPER_W(UPPER_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_low   (ld_low),
      .low_in   (host_wdata),
      .upper_in (host_wdata[UPPER_W-1:0]),
      .word     (word)
   );

   cs_parity_chk #(.HALF_W(HALF_W)) u_par (
      .word (word),
      .bad  (word_bad)
   );

   assign idx_rd = {prog_en, {(31 - IDX_W){1'b0}}, idx};

   // sticky parity error
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              parity_err <= 1'b0;
      else if (commit && par_chk_en && word_bad) parity_err <= 1'b1;
   end

   // store write port: registered or direct
   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               store_we    <= 1'b0;
               store_addr  <= '0;
               store_wdata <= '0;
            end else begin
               store_we <= commit;
               if (commit) begin
                  store_addr  <= idx;
                  store_wdata <= word;
               end
            end
         end
      end else begin : g_comb_out
         assign store_we    = commit;
         assign store_addr  = idx;
         assign store_wdata = word;
      end
   endgenerate

endmodule

// File: rtl/cs_prog_chk.sv
module cs_prog_chk #(
   parameter int DEPTH   = 4096,
   parameter int HALF_W  = 20,
   parameter bit OUT_REG = 1'b1,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int STORE_W = 2 * HALF_W + 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_wr,
   input logic [11:0]        host_offs,
   input logic               par_chk_en,
   input logic [31:0]        idx_rd,
   input logic               store_we,
   input logic [IDX_W-1:0]   store_addr,
   input logic [STORE_W-1:0] store_wdata,
   input logic               parity_err
);
   import cs_prog_pkg::*;

   localparam int INSN_W = 2 * HALF_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   logic wd_bad;
   assign wd_bad = ((^store_wdata[HALF_W-1:0]) != store_wdata[INSN_W]) ||
                   ((^store_wdata[INSN_W-1:HALF_W]) != store_wdata[INSN_W+1]);

   // R2: index register holds while disabled and not written
   a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!idx_rd[PROG_EN_BIT] && !(host_wr && host_offs == OFF_INDEX)) |=> $stable(idx_rd));

   // R8: error flag is sticky
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |=> parity_err);

   generate
      if (OUT_REG) begin : g_timed
         // R4 / R7: a strobe only follows an enabled upper write
         a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
            store_we |-> $past(host_wr && host_offs == OFF_HIGH && idx_rd[PROG_EN_BIT]));

         // R4: strobe address is the index seen by the write
         a_r4_addr_from_idx: assert property (@(posedge clk) disable iff (!rst_n)
            store_we |-> (store_addr == $past(idx_rd[IDX_W-1:0])));

         // R5 / R6: index advanced with wrap when the strobe appears
         a_r6_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            store_we |-> (idx_rd[IDX_W-1:0] ==
               ((store_addr == LAST_IDX) ? '0 : store_addr + IDX_W'(1))));

         // R8 / R9: flag only rises on a checked, failing commit
         a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(parity_err) |-> (store_we && wd_bad && $past(par_chk_en)));
      end
   endgenerate

endmodule

bind cs_prog_port cs_prog_chk #(.DEPTH(DEPTH), .HALF_W(HALF_W), .OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_wr     (host_wr),
   .host_offs   (host_offs),
   .par_chk_en  (par_chk_en),
   .idx_rd      (idx_rd),
   .store_we    (store_we),
   .store_addr  (store_addr),
   .store_wdata (store_wdata),
   .parity_err  (parity_err)
);

// File: tb/cs_prog_port_tb.sv
module cs_prog_port_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int IDX_W = $clog2(DEPTH);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [11:0] host_offs = '0;
   logic [31:0] host_wdata = '0;
   logic        par_chk_en = 1'b0;
   logic [31:0] idx_rd;
   logic        store_we;
   logic [IDX_W-1:0] store_addr;
   logic [41:0] store_wdata;
   logic        parity_err;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cs_prog_port #(.DEPTH(DEPTH)) u_dut (
      .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_offs (host_offs),
      .host_wdata (host_wdata), .par_chk_en (par_chk_en), .idx_rd (idx_rd),
      .store_we (store_we), .store_addr (store_addr), .store_wdata (store_wdata),
      .parity_err (parity_err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] o, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_offs = o; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_offs = '0; host_wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [41:0] mkword(input int i);
      logic [39:0] ins;
      ins = 40'((64'h13579BDF1 * (i + 1)) ^ (64'(i) << 7));
      return {^ins[39:20], ^ins[19:0], ins};
   endfunction

   // push one word; expects programming on; checks the commit
   task automatic push(input logic [41:0] w, input int exp_addr, input string tag);
      wr(12'h004, w[31:0]);
      chk({tag, " R3 no strobe on lower"}, 64'(store_we), 64'd0);
      wr(12'h008, {22'd0, w[41:32]});
      chk({tag, " R4 strobe"}, 64'(store_we), 64'd1);
      chk({tag, " R4 addr"}, 64'(store_addr), 64'(exp_addr));
      chk({tag, " R4 data"}, 64'(store_wdata), 64'(w));
      chk({tag, " R5 index"}, 64'(idx_rd), 64'(32'h80000000 | ((exp_addr + 1) % DEPTH)));
      @(negedge clk);
      chk({tag, " R4 single strobe"}, 64'(store_we), 64'd0);
   endtask

   initial begin
      logic [31:0] last_low;
      logic [41:0] w;
      do_reset();
      chk("R1 idx", 64'(idx_rd), 64'd0);
      chk("R1 we", 64'(store_we), 64'd0);
      chk("R1 err", 64'(parity_err), 64'd0);

      par_chk_en = 1'b1;
      wr(12'h000, 32'h80000000);
      chk("R2 enable", 64'(idx_rd), 64'h80000000);

      // full sweep through the store and past the end
      for (int i = 0; i <= DEPTH; i++) begin
         push(mkword(i), i % DEPTH, "sweep");
         if (i == DEPTH - 1) chk("R6 wrap readback", 64'(idx_rd), 64'h80000000);
      end
      chk("R8 no false error", 64'(parity_err), 64'd0);
      last_low = mkword(DEPTH)[31:0];

      // R10: unknown offset
      wr(12'h00C, 32'hFFFFFFFF);
      chk("R10 no strobe", 64'(store_we), 64'd0);
      chk("R10 idx", 64'(idx_rd), 64'h80000001);
      wr(12'h010, 32'h00000000);
      chk("R10 idx still", 64'(idx_rd), 64'h80000001);

      wr(12'h000, 32'h80000005);
      chk("R2 start index", 64'(idx_rd), 64'h80000005);
      wr(12'h000, 32'h00000000);
      chk("R2 end programming", 64'(idx_rd), 64'd0);

      // R7: data writes while disabled
      par_chk_en = 1'b0;
      wr(12'h004, 32'hDEADBEEF);
      chk("R7 lower ignored strobe", 64'(store_we), 64'd0);
      wr(12'h008, 32'h000003FF);
      chk("R7 upper ignored strobe", 64'(store_we), 64'd0);
      chk("R7 idx unchanged", 64'(idx_rd), 64'd0);
      wr(12'h000, 32'h80000003);
      wr(12'h008, 32'h00000155);
      chk("R7 staged lower kept", 64'(store_wdata), 64'({10'h155, last_low}));
      chk("R7 addr", 64'(store_addr), 64'd3);

      // R9: bad parity with check off
      w = mkword(20) ^ (42'd1 << 40);
      push(w, 4, "R9");
      chk("R9 no error when off", 64'(parity_err), 64'd0);

      // R8: lower-half parity failure, then stickiness
      par_chk_en = 1'b1;
      push(w, 5, "R8a");
      chk("R8 low half error", 64'(parity_err), 64'd1);
      push(mkword(21), 6, "R8b");
      chk("R8 sticky", 64'(parity_err), 64'd1);

      do_reset();
      chk("R1 err cleared", 64'(parity_err), 64'd0);
      chk("R1 idx cleared", 64'(idx_rd), 64'd0);
      wr(12'h000, 32'h80000007);
      push(mkword(3), 7, "R8c");
      chk("R8 good word no error", 64'(parity_err), 64'd0);
      push(mkword(4) ^ (42'd1 << 41), 0, "R8d");
      chk("R8 high half error", 64'(parity_err), 64'd1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule